// File: doc/BRIEF.md
# Phase Comparator with Lock Flag and One-Shot Fast-Lock Window

This block compares two timing strobes in a frequency-synthesis loop: the reference strobe (the divided crystal clock) and the feedback strobe (the divided oscillator output). Whichever strobe comes first opens a pump request. The request stays open until the other strobe arrives. The pump outputs therefore carry the phase error as a pulse width, in cycles of the block clock. When neither request is open, the pump driver outside the block floats its output. The block runs on the reference-oscillator clock, and both strobes are synchronous to it.

The block also produces three more outputs. The first is an active-low lock flag that drops for the length of each error pulse; a configuration bit can silence it. The second is a fast-lock window that opens once after reset, on the first error, and stays open for a fixed number of oscillator periods. The third is a boost enable that follows this window when boost is requested. A test pin together with a test-select bit can route one of the raw strobes onto the lock flag, and can pin the fast-lock output high.

Top module: `pfd_lock_unit`

## Requirements
- R1: A reference strobe that arrives while no request is open raises `pump_up` from the next cycle. `pump_up` stays high until the cycle after the feedback strobe, so its width in cycles equals the lead. `pump_dn` stays low.
- R2: A feedback strobe that arrives while no request is open raises `pump_dn` in the same way, with a width equal to the lead. `pump_up` stays low.
- R3: Strobes that arrive in the same cycle raise neither pump. Both pumps low is the high-impedance state; both pumps are never high together.
- R4: With `ld_enable` = 1 and `test_pin` = 0, `lock_n` is low exactly in the cycles where `pump_up` or `pump_dn` is high, and high otherwise.
- R5: With `ld_enable` = 0 and `test_pin` = 0, `lock_n` stays high whatever the phase error.
- R6: The first cycle after reset in which a pump is high opens the fast-lock window. `fl_out` then rises one cycle later and stays high for exactly WIN_CYCLES cycles (default 4).
- R7: The fast-lock window opens only once. Later errors do not reopen it; only a reset arms it again.
- R8: `boost_en` is high exactly while the fast-lock window is open and `boost_req` = 1. With `boost_req` = 0 it stays low.
- R9: With `test_pin` = 0, `test_sel` has no effect on `lock_n` or `fl_out`.
- R10: With `test_pin` = 1 and `test_sel` = 0, `lock_n` carries the feedback strobe and `fl_out` is held high.
- R11: With `test_pin` = 1 and `test_sel` = 1, `lock_n` carries the reference strobe and `fl_out` follows the fast-lock window.
- R12: While `rst_n` is low and after its release, before any strobe arrives, both pumps, `fl_out` and `boost_en` are low, and `lock_n` is high.
- R13: A second reference strobe that arrives while `pump_up` is already open neither extends nor restarts the pulse; the pulse still ends on the feedback strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference strobe, one cycle wide |
| vco_in | input | 1 | Feedback strobe from the oscillator divider, one cycle wide |
| ld_enable | input | 1 | 1 lets the lock flag show the error; 0 keeps it high |
| test_pin | input | 1 | Test pin; 1 selects the test routing |
| test_sel | input | 1 | Test-select bit; picks which strobe goes to the lock flag in test |
| boost_req | input | 1 | Requests the pump-current boost during the fast-lock window |
| pump_up | output | 1 | Pump request: raise the control voltage |
| pump_dn | output | 1 | Pump request: lower the control voltage |
| lock_n | output | 1 | Active-low lock flag, or a routed strobe in test |
| fl_out | output | 1 | Fast-lock window output |
| boost_en | output | 1 | Enables the second pump current (1.5x total) |

## Verification
The assertions assume that both strobes are single-cycle pulses. They also assume that `ld_enable`, `test_pin`, `test_sel` and `boost_req` stay fixed while a comparison is in flight. The stimulus changes these settings only between events, after both pumps and any open fast-lock window have gone quiet. Each event drives at most one extra reference strobe, and only while its own request is already open. The fast-lock assertions take reset as the only way to re-arm the one-shot; the bench re-arms it by applying reset in mid-run.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

   // routing chosen by the test pin and the test-select bit
   typedef enum logic [1:0] {
      PIN_NORMAL   = 2'd0,
      PIN_SHOW_VCO = 2'd1,
      PIN_SHOW_REF = 2'd2
   } pin_route_e;

   function automatic pin_route_e decode_route(input logic tpin, input logic tsel);
      pin_route_e r;
      if (!tpin)     r = PIN_NORMAL;
      else if (tsel) r = PIN_SHOW_REF;
      else           r = PIN_SHOW_VCO;
      return r;
   endfunction

   typedef struct packed {
      logic up;
      logic dn;
   } pump_req_t;

endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
   parameter bit STROBE_IN = 1'b1   // 1: inputs are strobes, 0: detect rising edges of levels
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ref_in,
   input  logic                    vco_in,
   output logic                    ref_stb,
   output logic                    vco_stb,
   output pfd_lock_pkg::pump_req_t pump
);
   import pfd_lock_pkg::*;

   generate
      if (STROBE_IN) begin : g_strobe
         assign ref_stb = ref_in;
         assign vco_stb = vco_in;
      end else begin : g_level
         logic ref_d, vco_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_d <= 1'b0;
               vco_d <= 1'b0;
            end else begin
               ref_d <= ref_in;
               vco_d <= vco_in;
            end
         end
         assign ref_stb = ref_in & ~ref_d;
         assign vco_stb = vco_in & ~vco_d;
      end
   endgenerate

   logic      ref_seen, vco_seen;
   pump_req_t state_q;

   assign ref_seen = state_q.up | ref_stb;
   assign vco_seen = state_q.dn | vco_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (ref_seen && vco_seen) begin
         state_q <= '0;          // both edges seen: clear at once
      end else begin
         state_q.up <= ref_seen;
         state_q.dn <= vco_seen;
      end
   end

   assign pump = state_q;

   // R1
   ref_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_stb && !vco_stb && !state_q.up && !state_q.dn) |=> (pump.up && !pump.dn));
   // R2
   vco_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vco_stb && !ref_stb && !state_q.up && !state_q.dn) |=> (pump.dn && !pump.up));
   // R3
   coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_stb && vco_stb && !state_q.up && !state_q.dn) |=> (!pump.up && !pump.dn));
   // R3
   no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump.up && pump.dn));
   // R13
   up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pump.up && !vco_stb) |=> pump.up);
   // R1
   up_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pump.up && vco_stb) |=> !pump.up);

endmodule

// File: rtl/pfd_lock_flag.sv
module pfd_lock_flag (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_enable,
   input  pfd_lock_pkg::pump_req_t pump,
   output logic                    ld_norm_n
);
   logic err;
   assign err       = pump.up | pump.dn;
   assign ld_norm_n = ~(ld_enable & err);

   // R5
   ld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_enable |-> ld_norm_n);
   // R4
   ld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pump.up && !pump.dn) |-> ld_norm_n);

endmodule

// File: rtl/pfd_boost_oneshot.sv
module pfd_boost_oneshot #(
   parameter int WIN_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic err,
   output logic win
);
   localparam int CNT_W = $clog2(WIN_CYCLES + 1);
   localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYCLES);

   initial begin
      if (WIN_CYCLES < 1) $fatal(1, "WIN_CYCLES must be at least 1");
   end

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q && err) begin
         armed_q <= 1'b0;
         cnt_q   <= WIN_LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign win = (cnt_q != '0);

   // R7
   once_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !win) |=> !win);
   // R6
   win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && err) |=> win);
   // R7
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> !armed_q);

endmodule

// File: rtl/pfd_pin_mux.sv
module pfd_pin_mux (
   input  logic test_pin,
   input  logic test_sel,
   input  logic ref_stb,
   input  logic vco_stb,
   input  logic ld_norm_n,
   input  logic fl_win,
   output logic lock_n,
   output logic fl_out
);
   import pfd_lock_pkg::*;

   pin_route_e route;
   assign route = decode_route(test_pin, test_sel);

   always_comb begin
      unique case (route)
         PIN_SHOW_VCO: begin
            lock_n = vco_stb;
            fl_out = 1'b1;
         end
         PIN_SHOW_REF: begin
            lock_n = ref_stb;
            fl_out = fl_win;
         end
         default: begin
            lock_n = ld_norm_n;
            fl_out = fl_win;
         end
      endcase
   end

endmodule

// File: rtl/pfd_lock_unit.sv
module pfd_lock_unit #(
   parameter int WIN_CYCLES = 4,
   parameter bit STROBE_IN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic vco_in,
   input  logic ld_enable,
   input  logic test_pin,
   input  logic test_sel,
   input  logic boost_req,
   output logic pump_up,
   output logic pump_dn,
   output logic lock_n,
   output logic fl_out,
   output logic boost_en
);
   import pfd_lock_pkg::*;

   pump_req_t pump;
   logic      ref_stb, vco_stb, ld_norm_n, fl_win;

   pfd_edge_core #(.STROBE_IN(STROBE_IN)) u_core (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
      .ref_stb(ref_stb), .vco_stb(vco_stb), .pump(pump)
   );

   pfd_lock_flag u_flag (
      .clk(clk), .rst_n(rst_n), .ld_enable(ld_enable), .pump(pump),
      .ld_norm_n(ld_norm_n)
   );

   pfd_boost_oneshot #(.WIN_CYCLES(WIN_CYCLES)) u_shot (
      .clk(clk), .rst_n(rst_n), .err(pump.up | pump.dn), .win(fl_win)
   );

   pfd_pin_mux u_mux (
      .test_pin(test_pin), .test_sel(test_sel), .ref_stb(ref_stb),
      .vco_stb(vco_stb), .ld_norm_n(ld_norm_n), .fl_win(fl_win),
      .lock_n(lock_n), .fl_out(fl_out)
   );

   assign pump_up  = pump.up;
   assign pump_dn  = pump.dn;
   assign boost_en = fl_win & boost_req;

   // R8
   boost_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boost_en |-> (boost_req && (fl_out || test_pin)));
   // R10
   fl_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_pin && !test_sel) |-> fl_out);
   // R4
   ld_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_pin && ld_enable && (pump_up || pump_dn)) |-> !lock_n);

endmodule

// File: tb/pfd_lock_unit_bench.sv
module pfd_lock_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WIN = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_in = 1'b0, vco_in = 1'b0;
   logic ld_enable = 1'b1, test_pin = 1'b0, test_sel = 1'b0, boost_req = 1'b1;
   logic pump_up, pump_dn, lock_n, fl_out, boost_en;

   pfd_lock_unit #(.WIN_CYCLES(WIN)) u_pfd_lock_unit (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
      .ld_enable(ld_enable), .test_pin(test_pin), .test_sel(test_sel),
      .boost_req(boost_req), .pump_up(pump_up), .pump_dn(pump_dn),
      .lock_n(lock_n), .fl_out(fl_out), .boost_en(boost_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int    cyc;
      logic  up, dn, ld, fl, bst;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_run = 0, n_fail = 0;
   bit   armed = 1'b1;
   int   fl_start = -1;
   bit   done = 1'b0;

   always @(posedge clk) cyc++;

   // monitor: pops expected items as their cycle comes up
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         n_run++;
         if (e.cyc != cyc ||
             {pump_up, pump_dn, lock_n, fl_out, boost_en} !== {e.up, e.dn, e.ld, e.fl, e.bst}) begin
            n_fail++;
            $display("FAIL %s cyc %0d: got up/dn/ld/fl/bst=%b%b%b%b%b expected %b%b%b%b%b",
                     e.req, cyc, pump_up, pump_dn, lock_n, fl_out, boost_en,
                     e.up, e.dn, e.ld, e.fl, e.bst);
         end
      end
   end

   task automatic check_idle(string req);
      n_run++;
      if ({pump_up, pump_dn, lock_n, fl_out, boost_en} !== 5'b00100) begin
         n_fail++;
         $display("FAIL %s idle: got %b%b%b%b%b expected 00100",
                  req, pump_up, pump_dn, lock_n, fl_out, boost_en);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R12");
      @(negedge clk); #1;
      rst_n = 1'b1;
      armed = 1'b1;
      fl_start = -1;
      @(negedge clk);
      check_idle("R12");
      #1;
   endtask

   // driver: pushes expectations for an event, then plays its strobes
   task automatic run_event(int lead, bit ref_first, bit dup, int tail, string req);
      int base, n;
      base = cyc;
      n = lead + tail + 1;
      if (lead > 0 && armed) begin
         fl_start = base + 2;
         armed = 1'b0;
      end
      for (int c = 1; c <= n; c++) begin
         exp_t e;
         int   t, o;
         bit   rs, vs, flw;
         t = base + c;
         o = c - 1;
         rs = ref_first ? (o == 0 || (dup && o == 1 && lead >= 2)) : (o == lead);
         vs = ref_first ? (o == lead) : (o == 0);
         e.cyc = t;
         e.up = ref_first && lead > 0 && c <= lead;
         e.dn = !ref_first && lead > 0 && c <= lead;
         flw = fl_start >= 0 && t >= fl_start && t < fl_start + WIN;
         if (test_pin) e.ld = test_sel ? rs : vs;
         else          e.ld = ld_enable ? !(e.up || e.dn) : 1'b1;
         e.fl  = (test_pin && !test_sel) ? 1'b1 : flw;
         e.bst = flw && boost_req;
         e.req = req;
         exp_q.push_back(e);
      end
      for (int c = 1; c <= n; c++) begin
         int o;
         o = c - 1;
         ref_in = ref_first ? (o == 0 || (dup && o == 1 && lead >= 2)) : (o == lead);
         vco_in = ref_first ? (o == lead) : (o == 0);
         @(negedge clk); #1;
      end
      ref_in = 1'b0;
      vco_in = 1'b0;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      check_idle("R12");               // R12 while reset held
      do_reset();
      // R1 R6 R8: first error opens the boost window
      run_event(3, 1'b1, 1'b0, 8, "R1/R6/R8");
      // R2 R7: feedback first, window must not reopen
      run_event(2, 1'b0, 1'b0, 8, "R2/R7");
      // R3: coincident strobes
      run_event(0, 1'b1, 1'b0, 3, "R3");
      // R13: extra reference strobe while up is open
      run_event(4, 1'b1, 1'b1, 3, "R13");
      // R5: lock flag silenced
      ld_enable = 1'b0;
      run_event(3, 1'b1, 1'b0, 3, "R5");
      run_event(2, 1'b0, 1'b0, 3, "R5");
      ld_enable = 1'b1;
      // R9: test select alone does nothing
      test_sel = 1'b1;
      run_event(2, 1'b1, 1'b0, 3, "R9");
      // R11: reference strobe on lock flag
      test_pin = 1'b1;
      run_event(3, 1'b1, 1'b0, 3, "R11");
      // R10: feedback strobe on lock flag, fast-lock pinned high
      test_sel = 1'b0;
      run_event(3, 1'b0, 1'b0, 3, "R10");
      test_pin = 1'b0;
      // R7 R8: reset re-arms, boost off
      boost_req = 1'b0;
      do_reset();
      run_event(2, 1'b1, 1'b0, 8, "R7/R8");
      // R11: window visible on fl_out under reference routing
      boost_req = 1'b1;
      do_reset();
      test_pin = 1'b1;
      test_sel = 1'b1;
      run_event(1, 1'b0, 1'b0, 8, "R11/R6");
      test_pin = 1'b0;
      // R4 R2: long lead
      run_event(10, 1'b0, 1'b0, 3, "R4/R2");
      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R4 queue: %0d left expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R12 watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule